// File: doc/BRIEF.md
# Single-Precision Floating-Point Subtractor

This block computes x minus y for two 32-bit IEEE 754 single-precision operands. The result is correctly rounded in one of four rounding modes. An invalid-operation flag and an inexact flag come with each result. Operands enter with a valid strobe, and the result appears on the registered outputs one clock later. A new operation can be issued on every cycle.

Each operand is sorted into one of six classes: signalling NaN, quiet NaN, zero, subnormal, normal or infinity. Any pair that contains a NaN, an infinity or a zero is resolved by a fixed priority order. All other pairs go through a shared add path with y's sign inverted. That path places the larger-magnitude operand first and aligns the smaller one with a right shift that keeps a sticky bit. It then adds or subtracts the extended significands, normalizes (stopping at the subnormal boundary), rounds and repacks. Overflow saturates to infinity or to the largest finite value, depending on the mode. Subnormal inputs and outputs are exact where the format allows.

Top module: `fpsub_unit`

## Requirements
- R1: After reset, out_valid, result and both flags are 0. out_valid equals in_valid of the previous cycle, and the outputs then carry the result for the operands presented in that cycle, in issue order with no gaps.
- R2: If x is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear), the result is x with bit 22 set and flag_invalid is 1, whatever y is.
- R3: If x is not a signalling NaN and y is one, the result is y with bit 22 set and flag_invalid is 1.
- R4: With no signalling NaN present, a quiet NaN in x returns x; otherwise a quiet NaN in y returns y. Both flags stay 0, and no output is ever a signalling NaN.
- R5: For infinity minus infinity with equal signs, the result is 0x7FC00000 with flag_invalid 1. With opposite signs, the result is x.
- R6: A finite x minus an infinite y gives infinity whose sign is the inverse of y's sign. An infinite x minus a finite y gives x.
- R7: For zero minus zero, differing signs return x. Equal signs return +0, except in mode 2'b11, which returns -0.
- R8: A nonzero finite x minus a zero gives x. A zero minus a nonzero finite y gives y with bit 31 inverted. Both flags are 0.
- R9: All other finite pairs give the correctly rounded difference for the rmode encoding: 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. flag_inexact is 1 exactly when the result differs from the true difference, and flag_invalid is 0.
- R10: When two equal nonzero finite operands are subtracted, the result is 0x80000000 in mode 2'b11 and 0x00000000 in every other mode, with flag_inexact 0.
- R11: On overflow, the result is infinity in mode 2'b00, in 2'b10 when positive and in 2'b11 when negative. In all other cases it is the largest finite value of that sign (exponent 254, fraction all ones). flag_inexact is 1.
- R12: Subnormal operands take part at full precision. A result below the normal range is packed with exponent field 0, and a subnormal result that reaches 2^-126 packs with exponent field 1.
- R13: When an effective addition carries past the leading bit, the exponent rises by one and the shifted-out bit still counts toward rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and rmode are valid this cycle |
| x_in | input | 32 | Minuend, IEEE 754 single |
| y_in | input | 32 | Subtrahend, IEEE 754 single |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result registers hold a new result |
| result | output | 32 | Difference x - y, IEEE 754 single |
| flag_invalid | output | 1 | Invalid operation for this result |
| flag_inexact | output | 1 | Result was rounded |

## Verification
Each result is registered exactly once, so every fault shows at the ports in the cycle after its operands are issued. A wrong class decode swaps one special-case row for another and changes the result word in that cycle. A misaligned or stale sticky bit shows up only in the lowest fraction bit or in flag_inexact, and only for ties or wide exponent gaps. For that reason the stimulus places ties, near-ties and gaps beyond the extended width side by side under all four modes. A normalization count that ignores the subnormal boundary gives a wrong exponent field on the very next result when two small operands are subtracted.

// File: rtl/fpsub_pkg.sv
package fpsub_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;

    typedef enum logic [2:0] {
        CL_ZERO, CL_SUB, CL_NORM, CL_INF, CL_QNAN, CL_SNAN
    } fclass_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;
endpackage

// File: rtl/fpsub_classify.sv
module fpsub_classify
    import fpsub_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW-1:0] mag,
    output fclass_e          cls
);
    logic [EW-1:0] ex;
    logic [FW-1:0] fr;

    always_comb begin
        ex = mag[EW+FW-1:FW];
        fr = mag[FW-1:0];
        if (&ex) begin
            if (fr == '0)          cls = CL_INF;
            else if (fr[FW-1])     cls = CL_QNAN;
            else                   cls = CL_SNAN;
        end else if (ex == '0) begin
            cls = (fr == '0) ? CL_ZERO : CL_SUB;
        end else begin
            cls = CL_NORM;
        end
    end
endmodule

// File: rtl/fpsub_special.sv
module fpsub_special
    import fpsub_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    localparam int WW = 1 + EW + FW
) (
    input  logic [WW-1:0] x,
    input  logic [WW-1:0] y,
    input  fclass_e       cx,
    input  fclass_e       cy,
    input  rmode_e        rm,
    output logic          hit,
    output logic [WW-1:0] res,
    output logic          inv
);
    localparam logic [WW-1:0] QBIT    = {{(WW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};
    localparam logic [WW-1:0] DEF_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    logic [WW-1:0] y_neg;

    always_comb begin
        y_neg = {~y[WW-1], y[WW-2:0]};
        hit   = 1'b1;
        inv   = 1'b0;
        res   = x;
        if (cx == CL_SNAN) begin
            res = x | QBIT;
            inv = 1'b1;
        end else if (cy == CL_SNAN) begin
            res = y | QBIT;
            inv = 1'b1;
        end else if (cx == CL_QNAN) begin
            res = x;
        end else if (cy == CL_QNAN) begin
            res = y;
        end else if (cx == CL_INF && cy == CL_INF) begin
            if (x[WW-1] != y[WW-1]) begin
                res = x;
            end else begin
                res = DEF_NAN;
                inv = 1'b1;
            end
        end else if (cy == CL_INF) begin
            res = y_neg;
        end else if (cx == CL_INF) begin
            res = x;
        end else if (cx == CL_ZERO && cy == CL_ZERO) begin
            res = (x[WW-1] != y[WW-1]) ? x : {rm == RM_DOWN, {(WW-1){1'b0}}};
        end else if (cy == CL_ZERO) begin
            res = x;
        end else if (cx == CL_ZERO) begin
            res = y_neg;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/fpsub_core.sv
module fpsub_core
    import fpsub_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    localparam int WW   = 1 + EW + FW,
    localparam int P    = FW + 1,
    localparam int W    = P + 3,
    localparam int EMAX = (1 << EW) - 1
) (
    input  logic [WW-1:0] x,
    input  logic [WW-1:0] y,
    input  rmode_e        rm,
    output logic [WW-1:0] res,
    output logic          inexact
);
    function automatic logic [EW:0] lead_zeros(input logic [W:0] v);
        logic [EW:0] n;
        logic        seen;
        n    = '0;
        seen = 1'b0;
        for (int i = W; i >= 0; i--) begin
            if (!seen) begin
                if (v[i]) seen = 1'b1;
                else      n = n + 1'b1;
            end
        end
        return n;
    endfunction

    logic            x_big, a_sign, b_sign, eff_sub, sign;
    logic [WW-2:0]   a_mag, b_mag;
    logic [EW-1:0]   a_exp, b_exp, d;
    logic [P-1:0]    a_man, b_man;
    logic [W-1:0]    a_ext, b_ext, b_al;
    logic [2*W-1:0]  shf;
    logic [W:0]      sum;
    logic [EW:0]     lz, lsh, cap, e_norm, e_fin;
    logic [W-1:0]    m_norm;
    logic            g, rs, lsb, any, up, to_inf;
    logic [P:0]      m_rnd;
    logic [FW-1:0]   frac;

    always_comb begin
        x_big  = (x[WW-2:0] >= y[WW-2:0]);
        a_mag  = x_big ? x[WW-2:0] : y[WW-2:0];
        b_mag  = x_big ? y[WW-2:0] : x[WW-2:0];
        a_sign = x_big ? x[WW-1] : ~y[WW-1];
        b_sign = x_big ? ~y[WW-1] : x[WW-1];
        eff_sub = a_sign ^ b_sign;

        a_exp = (a_mag[WW-2:FW] == '0) ? EW'(1) : a_mag[WW-2:FW];
        b_exp = (b_mag[WW-2:FW] == '0) ? EW'(1) : b_mag[WW-2:FW];
        a_man = {a_mag[WW-2:FW] != '0, a_mag[FW-1:0]};
        b_man = {b_mag[WW-2:FW] != '0, b_mag[FW-1:0]};
        a_ext = {a_man, 3'b000};
        b_ext = {b_man, 3'b000};

        d = a_exp - b_exp;
        if (d > EW'(W)) d = EW'(W);
        shf  = {b_ext, {W{1'b0}}} >> d;
        b_al = shf[2*W-1:W] | {{(W-1){1'b0}}, |shf[W-1:0]};

        sum = eff_sub ? ({1'b0, a_ext} - {1'b0, b_al})
                      : ({1'b0, a_ext} + {1'b0, b_al});
        lz  = lead_zeros(sum);
        sign = a_sign;

        cap = {1'b0, a_exp} - 1'b1;
        lsh = '0;
        if (sum[W]) begin
            m_norm = sum[W:1] | {{(W-1){1'b0}}, sum[0]};
            e_norm = {1'b0, a_exp} + 1'b1;
        end else begin
            lsh = lz - 1'b1;
            if (lsh > cap) lsh = cap;
            m_norm = sum[W-1:0] << lsh;
            e_norm = {1'b0, a_exp} - lsh;
        end

        lsb = m_norm[3];
        g   = m_norm[2];
        rs  = |m_norm[1:0];
        any = |m_norm[2:0];
        case (rm)
            RM_NEAR: up = g & (rs | lsb);
            RM_ZERO: up = 1'b0;
            RM_UP:   up = any & ~sign;
            default: up = any & sign;
        endcase
        m_rnd = {1'b0, m_norm[W-1:3]} + {{P{1'b0}}, up};

        if (m_rnd[P]) begin
            e_fin = e_norm + 1'b1;
            frac  = '0;
        end else begin
            e_fin = m_rnd[P-1] ? e_norm : '0;
            frac  = m_rnd[FW-1:0];
        end

        to_inf = (rm == RM_NEAR) || (rm == RM_UP && !sign) || (rm == RM_DOWN && sign);
        inexact = any;
        if (sum == '0) begin
            res     = {rm == RM_DOWN, {(WW-1){1'b0}}};
            inexact = 1'b0;
        end else if (e_fin >= (EW+1)'(EMAX)) begin
            inexact = 1'b1;
            res = to_inf ? {sign, {EW{1'b1}}, {FW{1'b0}}}
                         : {sign, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
        end else begin
            res = {sign, e_fin[EW-1:0], frac};
        end
    end
endmodule

// File: rtl/fpsub_unit.sv
module fpsub_unit
    import fpsub_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W,
    localparam int WW = 1 + EW + FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [WW-1:0] x_in,
    input  logic [WW-1:0] y_in,
    input  logic [1:0]    rmode,
    output logic          out_valid,
    output logic [WW-1:0] result,
    output logic          flag_invalid,
    output logic          flag_inexact
);
    typedef struct packed {
        logic          valid;
        logic [WW-1:0] res;
        logic          inv;
        logic          inx;
    } stage_t;

    stage_t        st_d, st_q;
    rmode_e        rm;
    logic [WW-2:0] mags [2];
    fclass_e       cls  [2];
    logic          sp_hit, sp_inv, core_inx;
    logic [WW-1:0] sp_res, core_res;

    assign rm      = rmode_e'(rmode);
    assign mags[0] = x_in[WW-2:0];
    assign mags[1] = y_in[WW-2:0];

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fpsub_classify #(.EW(EW), .FW(FW)) u_cls (
            .mag(mags[i]),
            .cls(cls[i])
        );
    end

    fpsub_special #(.EW(EW), .FW(FW)) u_special (
        .x(x_in), .y(y_in), .cx(cls[0]), .cy(cls[1]), .rm(rm),
        .hit(sp_hit), .res(sp_res), .inv(sp_inv)
    );

    fpsub_core #(.EW(EW), .FW(FW)) u_core (
        .x(x_in), .y(y_in), .rm(rm),
        .res(core_res), .inexact(core_inx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = sp_hit ? sp_res : core_res;
            st_d.inv = sp_hit & sp_inv;
            st_d.inx = ~sp_hit & core_inx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid    = st_q.valid;
    assign result       = st_q.res;
    assign flag_invalid = st_q.inv;
    assign flag_inexact = st_q.inx;
endmodule

// File: rtl/fpsub_sva.sv
module fpsub_sva #(
    parameter int EW = 8,
    parameter int FW = 23,
    localparam int WW = 1 + EW + FW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [WW-1:0] x_in,
    input logic [WW-1:0] y_in,
    input logic [1:0]    rmode,
    input logic          out_valid,
    input logic [WW-1:0] result,
    input logic          flag_invalid,
    input logic          flag_inexact
);
    localparam logic [WW-1:0] QBIT    = {{(WW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};
    localparam logic [WW-1:0] DEF_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    function automatic logic is_snan(input logic [WW-1:0] v);
        return (&v[WW-2:FW]) && (v[FW-1:0] != '0) && !v[FW-1];
    endfunction

    function automatic logic is_inf(input logic [WW-1:0] v);
        return (&v[WW-2:FW]) && (v[FW-1:0] == '0);
    endfunction

    p_valid_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_snan_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_snan(x_in)) |=> (flag_invalid && result == ($past(x_in) | QBIT)));
    p_snan_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_snan(x_in) && is_snan(y_in))
            |=> (flag_invalid && result == ($past(y_in) | QBIT)));
    p_no_snan_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !is_snan(result));
    p_inf_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_inf(x_in) && x_in == y_in) |=> (flag_invalid && result == DEF_NAN));
    p_inv_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> !flag_inexact);
    p_zero_diff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_in == y_in && !(&x_in[WW-2:FW]) && rmode != 2'b11)
            |=> (result == '0 && !flag_inexact));
endmodule

bind fpsub_unit fpsub_sva #(.EW(EW), .FW(FW)) u_sva (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
    .rmode(rmode), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
);

// File: tb/sim_fpsub_unit.sv
module sim_fpsub_unit;
    localparam logic [1:0] RNE = 2'b00, RTZ = 2'b01, RUP = 2'b10, RDN = 2'b11;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        logic        inx;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] x_in = '0, y_in = '0;
    logic [1:0]  rmode = '0;
    logic        out_valid, flag_invalid, flag_inexact;
    logic [31:0] result;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb [$];

    always #10 clk = ~clk;

    fpsub_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in), .y_in(y_in),
        .rmode(rmode), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    task automatic send(input logic [31:0] x, input logic [31:0] y, input logic [1:0] rm,
                        input logic [31:0] er, input logic ei, input logic ex, input string tag);
        item_t it;
        @(negedge clk);
        x_in = x; y_in = y; rmode = rm; in_valid = 1'b1;
        it.res = er; it.inv = ei; it.inx = ex; it.tag = tag;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result %h got valid 1 expected valid 0", result);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (result !== it.res || flag_invalid !== it.inv || flag_inexact !== it.inx) begin
                    errors++;
                    $display("FAIL %s got %h inv %b inx %b expected %h inv %b inx %b",
                             it.tag, result, flag_invalid, flag_inexact, it.res, it.inv, it.inx);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 32'h0 || flag_invalid !== 1'b0 || flag_inexact !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state got %b %h %b %b expected 0 0 0 0",
                     out_valid, result, flag_invalid, flag_inexact);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2: signalling NaN in x wins
        send(32'h7F800001, 32'h7FC00000, RNE, 32'h7FC00001, 1, 0, "R2 snan x vs qnan");
        send(32'h7FA00000, 32'hFF800002, RNE, 32'h7FE00000, 1, 0, "R2 snan x vs snan");
        // R3: signalling NaN in y
        send(32'h7FC00005, 32'hFF800002, RNE, 32'hFFC00002, 1, 0, "R3 qnan x snan y");
        send(32'h3F800000, 32'hFF800002, RTZ, 32'hFFC00002, 1, 0, "R3 one minus snan");
        // R4: quiet NaNs
        send(32'hFFC00003, 32'h7FC00004, RNE, 32'hFFC00003, 0, 0, "R4 qnan both");
        send(32'h3F800000, 32'h7FC00004, RNE, 32'h7FC00004, 0, 0, "R4 qnan y");
        send(32'h7FC00009, 32'h7F800000, RNE, 32'h7FC00009, 0, 0, "R4 qnan x inf y");
        // R5: infinity pairs
        send(32'h7F800000, 32'h7F800000, RNE, 32'h7FC00000, 1, 0, "R5 inf minus inf");
        send(32'h7F800000, 32'hFF800000, RNE, 32'h7F800000, 0, 0, "R5 inf minus -inf");
        send(32'hFF800000, 32'h7F800000, RNE, 32'hFF800000, 0, 0, "R5 -inf minus inf");
        // R6: one infinite operand
        send(32'h3F800000, 32'h7F800000, RNE, 32'hFF800000, 0, 0, "R6 one minus inf");
        send(32'h3F800000, 32'hFF800000, RNE, 32'h7F800000, 0, 0, "R6 one minus -inf");
        send(32'h00000000, 32'h7F800000, RNE, 32'hFF800000, 0, 0, "R6 zero minus inf");
        send(32'hFF800000, 32'h3F800000, RNE, 32'hFF800000, 0, 0, "R6 -inf minus one");
        // R7: zero pairs
        send(32'h00000000, 32'h80000000, RDN, 32'h00000000, 0, 0, "R7 +0 minus -0");
        send(32'h80000000, 32'h00000000, RNE, 32'h80000000, 0, 0, "R7 -0 minus +0");
        send(32'h00000000, 32'h00000000, RNE, 32'h00000000, 0, 0, "R7 +0 minus +0 rne");
        send(32'h00000000, 32'h00000000, RDN, 32'h80000000, 0, 0, "R7 +0 minus +0 rdn");
        send(32'h80000000, 32'h80000000, RUP, 32'h00000000, 0, 0, "R7 -0 minus -0 rup");
        // R8: one zero operand
        send(32'h3F800000, 32'h00000000, RNE, 32'h3F800000, 0, 0, "R8 one minus zero");
        send(32'h00000000, 32'h40400000, RNE, 32'hC0400000, 0, 0, "R8 zero minus three");
        send(32'h80000000, 32'hC0000000, RDN, 32'h40000000, 0, 0, "R8 -0 minus -2");
        send(32'h00000000, 32'h00000001, RNE, 32'h80000001, 0, 0, "R8 zero minus tiny");
        // R9: general finite cases
        send(32'h40400000, 32'h3F800000, RNE, 32'h40000000, 0, 0, "R9 three minus one");
        send(32'h3F800000, 32'h40400000, RNE, 32'hC0000000, 0, 0, "R9 one minus three");
        send(32'h3F800000, 32'h33800000, RNE, 32'h3F7FFFFF, 0, 0, "R9 exact renormalize");
        send(32'h3F800000, 32'h33000000, RNE, 32'h3F800000, 0, 1, "R9 tie up rne");
        send(32'h3F800000, 32'h33000000, RTZ, 32'h3F7FFFFF, 0, 1, "R9 tie rtz");
        send(32'h3F800000, 32'h33000000, RUP, 32'h3F800000, 0, 1, "R9 tie rup");
        send(32'h3F800000, 32'h33000000, RDN, 32'h3F7FFFFF, 0, 1, "R9 tie rdn");
        send(32'h3F800000, 32'hB3800000, RNE, 32'h3F800000, 0, 1, "R9 tie even down");
        send(32'h3F800000, 32'hB3800000, RUP, 32'h3F800001, 0, 1, "R9 tie rup add");
        send(32'h3F800000, 32'h30800000, RNE, 32'h3F800000, 0, 1, "R9 wide gap rne");
        send(32'h3F800000, 32'h30800000, RTZ, 32'h3F7FFFFF, 0, 1, "R9 wide gap rtz");
        send(32'h3F800000, 32'h30800000, RUP, 32'h3F800000, 0, 1, "R9 wide gap rup");
        // R10: exact zero difference
        send(32'h3F800000, 32'h3F800000, RNE, 32'h00000000, 0, 0, "R10 equal rne");
        send(32'h3F800000, 32'h3F800000, RDN, 32'h80000000, 0, 0, "R10 equal rdn");
        send(32'hC1200000, 32'hC1200000, RUP, 32'h00000000, 0, 0, "R10 equal neg rup");
        // R11: overflow
        send(32'h7F7FFFFF, 32'hFF7FFFFF, RNE, 32'h7F800000, 0, 1, "R11 ovf rne");
        send(32'h7F7FFFFF, 32'hFF7FFFFF, RTZ, 32'h7F7FFFFF, 0, 1, "R11 ovf rtz");
        send(32'h7F7FFFFF, 32'hFF7FFFFF, RDN, 32'h7F7FFFFF, 0, 1, "R11 ovf pos rdn");
        send(32'hFF7FFFFF, 32'h7F7FFFFF, RUP, 32'hFF7FFFFF, 0, 1, "R11 ovf neg rup");
        send(32'hFF7FFFFF, 32'h7F7FFFFF, RDN, 32'hFF800000, 0, 1, "R11 ovf neg rdn");
        // R12: subnormals
        send(32'h00000003, 32'h00000001, RNE, 32'h00000002, 0, 0, "R12 sub minus sub");
        send(32'h00800000, 32'h00000001, RNE, 32'h007FFFFF, 0, 0, "R12 normal to sub");
        send(32'h00400000, 32'h80400000, RNE, 32'h00800000, 0, 0, "R12 sub to normal");
        // R13: carry out of the leading bit
        send(32'h3FC00000, 32'hBFC00000, RNE, 32'h40400000, 0, 0, "R13 carry 1.5+1.5");
        send(32'h3F800000, 32'hBF800000, RTZ, 32'h40000000, 0, 0, "R13 carry 1+1");
        send(32'h4B7FFFFF, 32'hBF800000, RNE, 32'h4B800000, 0, 0, "R13 carry exact");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 pending results got %0d expected 0", sb.size());
        end
        finish_run();
    end
endmodule